// File: doc/BRIEF.md
# Indexed Block-Access SMBus Control Register Target

This block is an SMBus target that holds seven 8-bit control registers for a clock distribution buffer. It decodes those registers onto plain control pins. A host changes a run of consecutive registers in one transfer. It sends the beginning index, then a byte count, then exactly that many data bytes.

To read, the host first sets the index with a short write, then issues a repeated start with the read address. The target answers with a byte count and then the register contents. That count is not open ended: it comes from a writable count register.

The SCL and SDA lines are oversampled by the system clock through a two-flop synchroniser. Start and stop conditions are seen as SDA edges while SCL is high. A start or stop at any point abandons the transfer in progress. The target drives SDA only low, through `sda_oe`, and never stretches the clock. There is no streaming data path at the block edge, so every pin is a plain level.

Top module: `idxblk_smb_target`

## Requirements
- R1: After reset the registers hold the following values, and the outputs show them.
  - Index 0 = 0x07, so `pd_hiz`=0, `stop_hiz`=0, `bw_low`=1, `pll_mode`=1 and `div_full`=1.
  - Index 1 = 0xFF, so `out_en`=8'hFF.
  - Index 2 = 0x00, so `out_stoppable`=8'h00.
  - Index 3 = 0x00, index 4 = 0x11, index 5 = 0x08 and index 6 = 0x05.
  - `sda_oe` is 0.
- R2: The 7-bit device address is 0x6E. The address byte 0xDC (write) and the address byte 0xDD (read) are acknowledged. Any other address byte is not acknowledged, and every following byte is ignored and not acknowledged until the next start.
- R3: A write runs start, 0xDC, index N, count X, then X data bytes stored at indices N through N+X-1, then stop. Every one of those bytes is acknowledged. A data byte beyond X is not acknowledged and is not stored.
- R4: Index 4 is read-only and always reads 0x11. Index 3 is reserved and reads 0x00. Bits 5:3 of index 0 are reserved and read 0. Writes to read-only or reserved bits are acknowledged but have no effect.
- R5: Index 6 is the read count. After the read address is acknowledged, the first byte the target sends is the value of index 6. Writing index 6 changes that value.
- R6: The index advances by one after each stored data byte and after each data byte the host acknowledges in a read. A read returns index N first, then N+1, and so on.
- R7: When the host answers a read byte with a not-acknowledge, the target stops driving and releases SDA.
- R8: A start received in the middle of a transfer restarts address decoding and keeps the current index. A stop ends the transfer, and bytes already stored stay stored.
- R9: The target changes SDA only while SCL is low. It releases SDA after a stop.
- R10: Indices 7 and above read as 0x00. Writes to them are acknowledged and ignored.
- R11: The outputs follow the registers.
  - Index 0 bit 7 drives `pd_hiz`, bit 6 drives `stop_hiz`, bit 2 drives `bw_low`, bit 1 drives `pll_mode` and bit 0 drives `div_full`.
  - Index 1 drives `out_en`, bit i for output i.
  - Index 2 drives `out_stoppable`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pd_hiz | output | 1 | Power-down drive mode, 1 = high impedance |
| stop_hiz | output | 1 | Stop drive mode, 1 = high impedance |
| bw_low | output | 1 | Loop bandwidth select, 1 = low |
| pll_mode | output | 1 | 1 = PLL mode, 0 = fan-out bypass |
| div_full | output | 1 | 1 = full input rate, 0 = divide by two |
| out_en | output | 8 | Per-output enable, 1 = enabled |
| out_stoppable | output | 8 | Per-output stop select, 1 = stoppable |

## Verification
The assertions on SDA timing take for granted that the host keeps each SCL phase for at least three system clocks. They also assume the host moves SDA only while SCL is low, except to form a start or stop, and never forms a start or stop while the target holds SDA low. The bench drives a bit-banged host with a fixed quarter-bit of four clocks and changes SDA only after pulling SCL low. It forms repeated starts only from a released, idle-high line. Random writes put only 1 to 6 into the count register, so reads stay short and always acknowledge the count byte.

// File: rtl/ibt_pkg.sv
package ibt_pkg;
  localparam int DW = 8;
  localparam int NREG = 7;
  localparam int CNT_REG = 6;
  localparam int RO_REG = 4;
  localparam logic [6:0] DEV_ADDR = 7'h6E;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_SKIP
  } phase_t;

  typedef enum logic [1:0] {
    B_ADDR, B_IDX, B_CNT, B_DATA
  } role_t;

  function automatic logic [7:0] rst_val(input int i);
    case (i)
      0: return 8'h07;
      1: return 8'hFF;
      4: return 8'h11;
      5: return 8'h08;
      6: return 8'h05;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_mask(input int i);
    case (i)
      0: return 8'hC7;
      1, 2, 5, 6: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ibt_line_sync.sv
module ibt_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/ibt_reg_bank.sv
module ibt_reg_bank
  import ibt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] stp_q
);
  logic [NREG*DW-1:0] regs_flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] RV = rst_val(g);
    localparam logic [DW-1:0] WM = wr_mask(g);
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RV;
      else if (we && waddr == DW'(g)) q <= (wdata & WM) | (q & ~WM);
    end
    assign regs_flat[g*DW +: DW] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (raddr == DW'(i)) rdata = regs_flat[i*DW +: DW];
  end

  assign ctl_q = regs_flat[0*DW +: DW];
  assign en_q  = regs_flat[1*DW +: DW];
  assign stp_q = regs_flat[2*DW +: DW];
  assign cnt_q = regs_flat[CNT_REG*DW +: DW];

  // R5: a store to the count register is what the next read announces
  assert_count_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == DW'(CNT_REG)) |=> cnt_q == $past(wdata));

  // R4: the read-only identity byte survives a store
  assert_ro_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == DW'(RO_REG)) |=> $stable(regs_flat[RO_REG*DW +: DW]));
endmodule

// File: rtl/ibt_xfer_ctrl.sv
module ibt_xfer_ctrl
  import ibt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  input  logic [DW-1:0] cnt_val,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [DW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] rd_idx
);
  localparam int BW = $clog2(DW + 1);
  localparam logic [BW-1:0] LAST = BW'(DW);
  localparam logic [DW-1:0] ONE = DW'(1);

  phase_t        ph;
  role_t         role;
  logic [BW-1:0] bits;
  logic [DW-1:0] sh, idx, left;
  logic          rd_mode, hack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= S_IDLE;
      role      <= B_ADDR;
      bits      <= '0;
      sh        <= '0;
      idx       <= '0;
      left      <= '0;
      rd_mode   <= 1'b0;
      hack_q    <= 1'b0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (start_det) begin
        ph   <= S_RX;
        role <= B_ADDR;
        bits <= '0;
      end else if (stop_det) begin
        ph <= S_IDLE;
      end else begin
        case (ph)
          S_RX: begin
            if (scl_rise) begin
              sh   <= {sh[DW-2:0], sda_s};
              bits <= bits + 1'b1;
            end else if (scl_fall && bits == LAST) begin
              case (role)
                B_ADDR: begin
                  if (sh[DW-1:1] == DEV_ADDR) begin
                    ph      <= S_ACK;
                    rd_mode <= sh[0];
                    role    <= B_IDX;
                  end else begin
                    ph <= S_SKIP;
                  end
                end
                B_IDX: begin
                  idx  <= sh;
                  role <= B_CNT;
                  ph   <= S_ACK;
                end
                B_CNT: begin
                  left <= sh;
                  role <= B_DATA;
                  ph   <= S_ACK;
                end
                default: begin
                  if (left != '0) begin
                    reg_we    <= 1'b1;
                    reg_addr  <= idx;
                    reg_wdata <= sh;
                    idx       <= idx + ONE;
                    left      <= left - ONE;
                    ph        <= S_ACK;
                  end else begin
                    ph <= S_SKIP;
                  end
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              bits <= '0;
              if (rd_mode && role == B_IDX) begin
                ph <= S_TX;
                sh <= cnt_val;
              end else begin
                ph <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bits <= bits + 1'b1;
            end else if (scl_fall) begin
              if (bits == LAST) begin
                ph   <= S_RACK;
                bits <= '0;
              end else begin
                sh <= sh << 1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              hack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (hack_q) begin
                ph   <= S_TX;
                sh   <= rd_data;
                idx  <= idx + ONE;
                bits <= '0;
              end else begin
                ph <= S_SKIP;
              end
              hack_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = (ph == S_ACK) | ((ph == S_TX) & ~sh[DW-1]);
  assign rd_idx = idx;

  // R9: SDA moves only in the SCL low phase
  assert_sda_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R9: a stop always leaves the line released
  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R3: each stored byte consumes one unit of the announced count
  assert_count_consumed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> left == $past(left) - ONE);

  // R6: the index has moved past the byte just stored
  assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> idx == reg_addr + ONE);
endmodule

// File: rtl/idxblk_smb_target.sv
module idxblk_smb_target
  import ibt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       pd_hiz,
  output logic       stop_hiz,
  output logic       bw_low,
  output logic       pll_mode,
  output logic       div_full,
  output logic [7:0] out_en,
  output logic [7:0] out_stoppable
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          we;
  logic [DW-1:0] waddr, wdata, ridx, rdata, cnt_q, ctl_q, en_q, stp_q;

  ibt_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ibt_xfer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rdata), .cnt_val(cnt_q), .sda_oe(sda_oe),
    .reg_we(we), .reg_addr(waddr), .reg_wdata(wdata), .rd_idx(ridx)
  );

  ibt_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(ridx), .rdata(rdata), .cnt_q(cnt_q), .ctl_q(ctl_q),
    .en_q(en_q), .stp_q(stp_q)
  );

  assign pd_hiz        = ctl_q[7];
  assign stop_hiz      = ctl_q[6];
  assign bw_low        = ctl_q[2];
  assign pll_mode      = ctl_q[1];
  assign div_full      = ctl_q[0];
  assign out_en        = en_q;
  assign out_stoppable = stp_q;
endmodule

// File: tb/idxblk_smb_target_tb.sv
module idxblk_smb_target_tb;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe, pd_hiz, stop_hiz, bw_low, pll_mode, div_full;
  logic [7:0] out_en, out_stoppable;
  logic sda_bus;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] mdl [0:6];
  logic [7:0] wbuf [0:7];

  always #10 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;

  idxblk_smb_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .pd_hiz(pd_hiz), .stop_hiz(stop_hiz), .bw_low(bw_low),
    .pll_mode(pll_mode), .div_full(div_full), .out_en(out_en),
    .out_stoppable(out_stoppable)
  );

  function automatic logic [7:0] m_rst(input int i);
    case (i)
      0: return 8'h07; 1: return 8'hFF; 4: return 8'h11;
      5: return 8'h08; 6: return 8'h05; default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_mask(input int i);
    case (i)
      0: return 8'hC7; 1, 2, 5, 6: return 8'hFF; default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_read(input int i);
    return (i < 7) ? mdl[i] : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bstop();
    sda_h = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
    end
    sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    acked = ~sda_bus;
    scl = 1'b0; tick(Q);
  endtask

  task automatic rx_byte(input logic ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q);
      b = {b[6:0], sda_bus};
      scl = 1'b0;
    end
    sda_h = ~ack; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    sda_h = 1'b1;
  endtask

  task automatic do_write(input int n, input int x, input int extra);
    logic a;
    bstart();
    tx_byte(8'hDC, a); chk("R2 write address ack", a, 1);
    tx_byte(8'(n), a); chk("R3 index ack", a, 1);
    tx_byte(8'(x), a); chk("R3 count ack", a, 1);
    for (int i = 0; i < x; i++) begin
      tx_byte(wbuf[i], a); chk("R3 data ack", a, 1);
      if (n + i < 7) mdl[n+i] = (wbuf[i] & m_mask(n+i)) | (mdl[n+i] & ~m_mask(n+i));
    end
    for (int i = 0; i < extra; i++) begin
      tx_byte(8'hA5, a); chk("R3 excess byte nack", a, 0);
    end
    bstop();
  endtask

  task automatic read_body(input int n);
    logic a;
    logic [7:0] b;
    int c;
    bstart();
    tx_byte(8'hDD, a); chk("R2 read address ack", a, 1);
    c = int'(mdl[6]);
    rx_byte(1'b1, b); chk("R5 count byte", b, mdl[6]);
    for (int i = 0; i < c; i++) begin
      rx_byte(i < c - 1, b);
      chk((n + i > 6) ? "R10 beyond last index" : "R6 read data", b, m_read(n + i));
    end
    tick(2);
    chk("R7 released after nack", sda_oe, 0);
    bstop();
  endtask

  task automatic do_read(input int n);
    logic a;
    bstart();
    tx_byte(8'hDC, a); chk("R2 write address ack", a, 1);
    tx_byte(8'(n), a); chk("R6 index ack", a, 1);
    read_body(n);
  endtask

  task automatic chk_outs(input string tag);
    chk(tag, {pd_hiz, stop_hiz, bw_low, pll_mode, div_full},
        {mdl[0][7], mdl[0][6], mdl[0][2], mdl[0][1], mdl[0][0]});
    chk(tag, out_en, mdl[1]);
    chk(tag, out_stoppable, mdl[2]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic a;
    int seed_init;
    seed_init = $urandom(32'd2024);
    for (int i = 0; i < 7; i++) mdl[i] = m_rst(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    chk_outs("R1 reset outputs");
    chk("R1 sda released", sda_oe, 0);

    // R5 / R6: default count of 5 reads indices 0..4
    do_read(0);

    // R4: read-only and reserved stores ignored
    wbuf[0] = 8'hFF; wbuf[1] = 8'h55;
    do_write(3, 2, 0);
    wbuf[0] = 8'hFF;
    do_write(0, 1, 0);
    do_read(0);
    chk_outs("R11 control decode");

    // R3: byte past the count is refused
    wbuf[0] = 8'h0F;
    do_write(1, 1, 1);
    do_read(1);
    chk_outs("R3 excess not stored");

    // R2: foreign address ignored until next start
    bstart();
    tx_byte(8'hA0, a); chk("R2 foreign address nack", a, 0);
    tx_byte(8'h01, a); chk("R2 ignored byte nack", a, 0);
    tx_byte(8'h00, a); chk("R2 ignored byte nack", a, 0);
    bstop();
    chk_outs("R2 state untouched");

    // R8: repeated start mid-write keeps the index
    bstart();
    tx_byte(8'hDC, a); chk("R8 address ack", a, 1);
    tx_byte(8'h05, a); chk("R8 index ack", a, 1);
    tx_byte(8'h02, a); chk("R8 count ack", a, 1);
    tx_byte(8'h3C, a); chk("R8 data ack", a, 1);
    mdl[5] = 8'h3C;
    read_body(6);

    // R8: stop mid-write keeps stored bytes
    bstart();
    tx_byte(8'hDC, a); tx_byte(8'h01, a); tx_byte(8'h03, a);
    tx_byte(8'hF0, a); chk("R8 data ack", a, 1);
    mdl[1] = 8'hF0;
    bstop();
    chk_outs("R8 stop keeps stored");
    do_read(1);

    // R10: beyond last index
    wbuf[0] = 8'h02;
    do_write(6, 1, 0);
    wbuf[0] = 8'h77;
    do_write(8, 1, 0);
    do_read(7);
    do_read(5);

    // random traffic
    for (int it = 0; it < 20; it++) begin
      int n, x, ex;
      n  = int'($urandom_range(0, 7));
      x  = int'($urandom_range(0, 3));
      ex = int'($urandom_range(0, 1));
      for (int i = 0; i < x; i++) begin
        wbuf[i] = 8'($urandom);
        if (n + i == 6) wbuf[i] = 8'(($urandom % 6) + 1);
      end
      do_write(n, x, ex);
      chk_outs("R11 outputs follow registers");
      do_read(int'($urandom_range(0, 8)));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule